// File: doc/BRIEF.md
# Memory Buffer Block Counter and Shared-Link Arbiter

This block controls one memory link that two masters share. The capture side writes sample blocks into memory. The transfer side reads them back out toward a downstream dual-clock FIFO. The block grants the link to one master at a time, and a pending write always beats a pending read.

The block keeps an up/down count of complete blocks that sit in memory and have not been read yet. It starts a block read only when four things are true:

- a transfer has been started;
- the transfer still has blocks left to read;
- at least one block is pending;
- the downstream FIFO reports space.

Every completed read moves the read address forward by one block of eight words. Every completed read also counts toward the programmed total. When the total is reached, a completion flag rises and stays up until software starts the next transfer.

Each block on the link is one transaction. A grant stays held until the memory side reports that the block is finished, so arbitration happens only between blocks.

Top module: `blkbuf_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising edge, the registered outputs go to these values: both grants 0, `rd_req` 0, `xfer_done` 0, `pend_blocks` 0 and `rd_addr` 0. Reset takes priority over every other input.
- R2: The link must be idle (no grant) for a request to be taken. If `wr_req` is high at a rising edge while the link is idle, `wr_gnt` is high after that edge. This holds even when a read would also be eligible, because a write always wins.
- R3: Once a grant is given, it stays high until the edge that samples `blk_done` high. Changes on `wr_req` and `fifo_full` during the grant have no effect on it.
- R4: At the edge that samples `blk_done` under a write grant, `pend_blocks` goes up by one. At the edge that samples `blk_done` under a read grant, `pend_blocks` goes down by one.
- R5: A read grant is given only when all of the following hold at the sampling edge:
  - the link is idle;
  - `wr_req` is low;
  - a transfer has been started;
  - completed reads are below the latched total;
  - `pend_blocks` is nonzero;
  - `fifo_full` is low.
- R6: `rd_req` is high for exactly one cycle. That cycle is the first cycle of each read grant.
- R7: `rd_addr` is a word address. At each completed read it advances by 8, which is one block, and it wraps modulo 2^ADDR_W.
- R8: A `start` pulse does three things: it latches `total_blocks`, clears the completed-read count and enables reads. `xfer_done` is high whenever a transfer has been started and its completed reads equal the latched total. This includes a total of zero. It stays high until the next `start`.
- R9: The two grants are never high together. After a grant ends, there is at least one cycle with no grant.
- R10: If `blk_done` arrives while there is no grant, it changes neither `pend_blocks` nor `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that begins a new transfer and latches `total_blocks` |
| total_blocks | input | TOT_W | Number of blocks the transfer must read |
| wr_req | input | 1 | Capture master has a block to write |
| fifo_full | input | 1 | Downstream FIFO has no room for another block |
| blk_done | input | 1 | Memory side finished the current block transaction |
| wr_gnt | output | 1 | Link granted to the write master |
| rd_gnt | output | 1 | Link granted to the read master |
| rd_req | output | 1 | One-cycle strobe that launches a block read |
| xfer_done | output | 1 | Programmed number of blocks has been read |
| rd_addr | output | ADDR_W | Word address of the next block to read |
| pend_blocks | output | PEND_W | Blocks written but not yet read |

## Verification
Each result is due on a fixed edge:

- A grant and the `rd_req` strobe appear after the first rising edge that samples the request while the link is idle.
- `pend_blocks`, `rd_addr` and a grant release update on the edge that samples `blk_done`.
- `xfer_done` follows one edge after `start` or after the final read completion.

The bench drives every input on a falling edge. It checks one nanosecond after the next rising edge, comparing all outputs against a model of the requirements that is advanced exactly once per driven cycle. Each prediction is therefore compared with the state produced by the single edge that follows its stimulus.

// File: rtl/bbc_pkg.sv
// Shared definitions for the block buffer arbiter.
// Assumes: nothing beyond a single clock domain.
package bbc_pkg;

    // Ownership of the shared memory link.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WR   = 2'd1,
        ARB_RD   = 2'd2
    } arb_st_t;

    // Words carried by one block transaction.
    localparam int BLOCK_WORDS = 8;

endpackage

// File: rtl/bba_arbiter.sv
// Fixed-priority owner of the shared memory link.
// The write master wins over the read master. A grant is held until
// blk_done, and a new grant starts only from the idle state, so at
// least one idle cycle separates two grants.
// Assumes: blk_done is meaningful only while a grant is active.
module bba_arbiter
    import bbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_req,
    input  logic rd_want,
    input  logic blk_done,
    output logic wr_gnt,
    output logic rd_gnt,
    output logic rd_req,
    output logic wr_fin,
    output logic rd_fin
);

    arb_st_t st_q, st_d;
    logic    rd_req_q;

    // Next owner: writes first, then eligible reads, release on completion.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (wr_req)       st_d = ARB_WR;
                else if (rd_want) st_d = ARB_RD;
            end
            ARB_WR, ARB_RD: begin
                if (blk_done)     st_d = ARB_IDLE;
            end
            default:              st_d = ARB_IDLE;
        endcase
    end

    // Owner register plus the one-cycle read launch strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ARB_IDLE;
            rd_req_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            rd_req_q <= (st_q == ARB_IDLE) && !wr_req && rd_want;
        end
    end

    assign wr_gnt = (st_q == ARB_WR);
    assign rd_gnt = (st_q == ARB_RD);
    assign rd_req = rd_req_q;
    assign wr_fin = wr_gnt && blk_done;
    assign rd_fin = rd_gnt && blk_done;

endmodule

// File: rtl/bba_blk_counter.sv
// Up/down count of complete blocks held in memory.
// If inc and dec arrive together the count is unchanged.
// Assumes: the writer never overfills memory and dec never hits an empty
// count (the read launch already requires a nonzero count).
module bba_blk_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Count update on block completions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   count <= count + ONE;
                2'b01:   count <= count - ONE;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/bba_read_ctrl.sv
// Transfer bookkeeping on the read side: latched total, completed reads,
// read eligibility, completion flag and the block read address.
// Assumes: start is pulsed only while no read grant is outstanding.
module bba_read_ctrl #(
    parameter int TOT_W     = 32,
    parameter int ADDR_W    = 20,
    parameter int PEND_W    = 12,
    parameter int BLK_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TOT_W-1:0]  total,
    input  logic              fifo_full,
    input  logic [PEND_W-1:0] pend,
    input  logic              rd_fin,
    output logic              rd_want,
    output logic              xfer_done,
    output logic [ADDR_W-1:0] rd_addr
);

    localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(BLK_WORDS);
    localparam logic [TOT_W-1:0]  CNT_ONE   = TOT_W'(1);

    logic             active_q;
    logic [TOT_W-1:0] tot_q;
    logic [TOT_W-1:0] done_cnt_q;

    // Transfer setup on start, completed-read tally otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            tot_q      <= '0;
            done_cnt_q <= '0;
        end else if (start) begin
            active_q   <= 1'b1;
            tot_q      <= total;
            done_cnt_q <= '0;
        end else if (rd_fin) begin
            done_cnt_q <= done_cnt_q + CNT_ONE;
        end
    end

    // Read address moves one block per finished read, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_addr <= '0;
        else if (rd_fin) rd_addr <= rd_addr + ADDR_STEP;
    end

    assign xfer_done = active_q && (done_cnt_q == tot_q);
    assign rd_want   = active_q && (done_cnt_q != tot_q) &&
                       (pend != '0) && !fifo_full;

endmodule

// File: rtl/blkbuf_arbiter.sv
// Top of the block buffer arbiter. It joins the fixed-priority link
// arbiter, the pending-block counter and the read-side controller.
// Assumes: one block per grant, with blk_done marking its end.
module blkbuf_arbiter #(
    parameter int TOT_W  = 32,
    parameter int ADDR_W = 20,
    parameter int PEND_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [TOT_W-1:0]  total_blocks,
    input  logic              wr_req,
    input  logic              fifo_full,
    input  logic              blk_done,
    output logic              wr_gnt,
    output logic              rd_gnt,
    output logic              rd_req,
    output logic              xfer_done,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PEND_W-1:0] pend_blocks
);

    logic rd_want;
    logic wr_fin;
    logic rd_fin;

    bba_arbiter u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (wr_req),
        .rd_want  (rd_want),
        .blk_done (blk_done),
        .wr_gnt   (wr_gnt),
        .rd_gnt   (rd_gnt),
        .rd_req   (rd_req),
        .wr_fin   (wr_fin),
        .rd_fin   (rd_fin)
    );

    bba_blk_counter #(.CNT_W(PEND_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (wr_fin),
        .dec   (rd_fin),
        .count (pend_blocks)
    );

    bba_read_ctrl #(
        .TOT_W     (TOT_W),
        .ADDR_W    (ADDR_W),
        .PEND_W    (PEND_W),
        .BLK_WORDS (bbc_pkg::BLOCK_WORDS)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .total     (total_blocks),
        .fifo_full (fifo_full),
        .pend      (pend_blocks),
        .rd_fin    (rd_fin),
        .rd_want   (rd_want),
        .xfer_done (xfer_done),
        .rd_addr   (rd_addr)
    );

endmodule

// File: rtl/blkbuf_arbiter_chk.sv
// Protocol checker for blkbuf_arbiter, attached through bind.
// Assumes: it observes the top-level ports only.
module blkbuf_arbiter_chk #(
    parameter int ADDR_W = 20,
    parameter int PEND_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              wr_req,
    input logic              fifo_full,
    input logic              blk_done,
    input logic              wr_gnt,
    input logic              rd_gnt,
    input logic              rd_req,
    input logic              xfer_done,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [PEND_W-1:0] pend_blocks
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(bbc_pkg::BLOCK_WORDS);
    localparam logic [PEND_W-1:0] ONE  = PEND_W'(1);

    p_wr_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_gnt && !rd_gnt && wr_req) |=> wr_gnt);

    p_hold_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt && !blk_done) |=> wr_gnt);

    p_hold_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt && !blk_done) |=> rd_gnt);

    p_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_gnt && blk_done) |=> (pend_blocks == $past(pend_blocks) + ONE));

    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt && blk_done) |=> (pend_blocks == $past(pend_blocks) - ONE));

    p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (!$past(fifo_full) && ($past(pend_blocks) != '0) &&
                    !$past(xfer_done) && !$past(wr_req)));

    p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> rd_gnt);

    p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    p_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_gnt) |-> rd_req);

    p_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_gnt && blk_done) |=> (rd_addr == $past(rd_addr) + STEP));

    p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !start) |=> xfer_done);

    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_gnt && rd_gnt));

    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_gnt || rd_gnt) && blk_done) |=> (!wr_gnt && !rd_gnt));

    p_stray_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_gnt && !rd_gnt) |=> ($stable(pend_blocks) && $stable(rd_addr)));

endmodule

bind blkbuf_arbiter blkbuf_arbiter_chk #(
    .ADDR_W (ADDR_W),
    .PEND_W (PEND_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .wr_req      (wr_req),
    .fifo_full   (fifo_full),
    .blk_done    (blk_done),
    .wr_gnt      (wr_gnt),
    .rd_gnt      (rd_gnt),
    .rd_req      (rd_req),
    .xfer_done   (xfer_done),
    .rd_addr     (rd_addr),
    .pend_blocks (pend_blocks)
);

// File: tb/blkbuf_arbiter_tb.sv
// Scoreboard bench: step() drives one cycle of stimulus on the falling
// edge, advances a requirement model and queues the expected outputs.
// A monitor compares them 1 ns after the following rising edge.
module blkbuf_arbiter_tb;

    localparam int TOT_W  = 8;
    localparam int ADDR_W = 5;
    localparam int PEND_W = 6;
    localparam int AMOD   = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [TOT_W-1:0]  total_blocks = '0;
    logic              wr_req = 1'b0;
    logic              fifo_full = 1'b0;
    logic              blk_done = 1'b0;
    logic              wr_gnt, rd_gnt, rd_req, xfer_done;
    logic [ADDR_W-1:0] rd_addr;
    logic [PEND_W-1:0] pend_blocks;

    always #2 clk = ~clk;

    blkbuf_arbiter #(.TOT_W(TOT_W), .ADDR_W(ADDR_W), .PEND_W(PEND_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .total_blocks(total_blocks),
        .wr_req(wr_req), .fifo_full(fifo_full), .blk_done(blk_done),
        .wr_gnt(wr_gnt), .rd_gnt(rd_gnt), .rd_req(rd_req),
        .xfer_done(xfer_done), .rd_addr(rd_addr), .pend_blocks(pend_blocks)
    );

    typedef struct {
        string tag;
        logic  wg;
        logic  rg;
        logic  rq;
        logic  dn;
        int    pend;
        int    addr;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_bad    = 0;
    bit   finished = 0;

    // Requirement model state.
    int m_st = 0;   // 0 idle, 1 write, 2 read
    int m_pend = 0, m_cnt = 0, m_tot = 0, m_addr = 0;
    bit m_act = 0, m_rq = 0;

    task automatic step(input string tag, input logic rst, input logic st,
                        input int tot, input logic wq, input logic ff,
                        input logic bd);
        exp_t e;
        bit   want;
        @(negedge clk);
        rst_n = rst; start = st; total_blocks = TOT_W'(tot);
        wr_req = wq; fifo_full = ff; blk_done = bd;
        if (!rst) begin
            m_st = 0; m_pend = 0; m_cnt = 0; m_tot = 0;
            m_addr = 0; m_act = 0; m_rq = 0;
        end else begin
            want = m_act && (m_cnt != m_tot) && (m_pend != 0) && !ff;
            m_rq = 0;
            case (m_st)
                0: if (wq) m_st = 1;
                   else if (want) begin m_st = 2; m_rq = 1; end
                1: if (bd) begin m_pend++; m_st = 0; end
                default: if (bd) begin
                    m_pend--; m_cnt++; m_addr = (m_addr + 8) % AMOD; m_st = 0;
                end
            endcase
            if (st) begin m_act = 1; m_tot = tot; m_cnt = 0; end
        end
        e.tag = tag; e.wg = (m_st == 1); e.rg = (m_st == 2); e.rq = m_rq;
        e.dn = m_act && (m_cnt == m_tot); e.pend = m_pend; e.addr = m_addr;
        q.push_back(e);
    endtask

    task automatic idle(input string tag, input int n);
        for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0, 0, 0);
    endtask

    // Monitor: compare the queued prediction after each rising edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (wr_gnt !== e.wg || rd_gnt !== e.rg || rd_req !== e.rq ||
                xfer_done !== e.dn || int'(pend_blocks) != e.pend ||
                int'(rd_addr) != e.addr) begin
                n_bad++;
                $display("FAIL %s: got wg=%b rg=%b rq=%b dn=%b pend=%0d addr=%0d exp wg=%b rg=%b rq=%b dn=%b pend=%0d addr=%0d",
                         e.tag, wr_gnt, rd_gnt, rd_req, xfer_done, pend_blocks,
                         rd_addr, e.wg, e.rg, e.rq, e.dn, e.pend, e.addr);
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", n_checks + 1, n_bad);
            $finish;
        end
    end

    initial begin
        step("R1", 0, 0, 0, 1, 0, 1);
        step("R1", 0, 0, 0, 0, 0, 0);
        // Write a block while no transfer is running.
        step("R2", 1, 0, 0, 1, 0, 0);
        step("R3", 1, 0, 0, 0, 1, 0);
        step("R4", 1, 0, 0, 0, 0, 1);
        idle("R5", 3);                  // pending block, but no start
        step("R10", 1, 0, 0, 0, 0, 1);  // stray completion ignored
        // Transfer of three blocks.
        step("R8", 1, 1, 3, 0, 0, 0);
        step("R6", 1, 0, 0, 0, 0, 0);   // read launches
        step("R6", 1, 0, 0, 0, 0, 0);   // strobe gone, grant held
        step("R3", 1, 0, 0, 1, 1, 0);   // write request cannot break read
        step("R7", 1, 0, 0, 1, 0, 1);   // read ends, address +8
        step("R2", 1, 0, 0, 1, 0, 0);   // write granted after idle gap
        step("R4", 1, 0, 0, 0, 0, 1);
        step("R5", 1, 0, 0, 0, 1, 0);   // FIFO full holds read back
        step("R5", 1, 0, 0, 0, 1, 0);
        step("R2", 1, 0, 0, 1, 0, 0);   // both eligible: write wins
        step("R4", 1, 0, 0, 0, 0, 1);
        step("R6", 1, 0, 0, 0, 0, 0);
        step("R9", 1, 0, 0, 0, 0, 1);
        step("R9", 1, 0, 0, 0, 0, 0);   // next read after a gap
        step("R8", 1, 0, 0, 0, 0, 1);   // third read completes transfer
        idle("R8", 2);
        step("R2", 1, 0, 0, 1, 0, 0);
        step("R4", 1, 0, 0, 0, 0, 1);
        idle("R5", 3);                  // total reached: no more reads
        step("R8", 1, 1, 0, 0, 0, 0);   // zero total: done at once
        step("R8", 1, 1, 2, 0, 0, 0);   // new start clears done
        step("R6", 1, 0, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 0, 0, 1);   // fourth read wraps address to 0
        idle("R5", 2);
        step("R1", 0, 0, 0, 1, 0, 1);   // reset mid-run
        idle("R1", 1);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule